// File: doc/BRIEF.md
# Duplicated Parity-Checked Register File

This block is a processor-style register file of 32-bit words with two combinational read ports and one write port. Every word is held in two identical storage copies. Each copy stores its word together with eight check bits, one even-parity bit per 4-bit nibble. On every read, the check bits are recomputed and compared with the stored ones. When exactly one copy disagrees with its check bits, the port returns the word from the healthy copy. A repair write then restores both copies in the next cycle that carries no ordinary write.

A control/status register governs the protection. It holds a disable bit that turns checking off, a test-enable bit, and a copy-select bit. It also holds eight test bits that are XORed into the check bits of one chosen copy on ordinary writes, which deliberately plants detectable faults. A saturating 3-bit counter records corrected errors, and software clears it by writing the register. The control register also carries a fixed read-only field that identifies the protection scheme.

Top module: `dupar_regfile`

## Requirements
- R1: A write with `wr_en` high to a nonzero address stores `wr_data`. From the next cycle on, either read port returns that word combinationally for its address.
- R2: Address 0 always reads as zero on both ports. Writes to it are discarded, and reads of it are never checked or counted.
- R3: `csr_rdata` layout: bit 0 disable, bit 1 test enable, bit 2 copy select (0 = first copy, 1 = second copy), bits 10:3 test bits, bits 13:11 error counter, bits 15:14 a read-only scheme ID of binary 10. Every other bit reads 0. A write updates every field except the ID.
- R4: With test enable set, an ordinary write stores check bits equal to the correct nibble parity XOR the test bits in the selected copy only. The other copy always receives correct parity. With test enable clear, the test bits have no effect.
- R5: A read with its port's enable high to a nonzero address, with protection on, where exactly one copy fails its parity check, returns the healthy copy's word. It adds one to the counter at the end of that cycle.
- R6: A corrected read queues a repair. The repair rewrites both copies with correct parity in the next cycle whose `wr_en` is low, so a later read of that address causes no count.
- R7: When both ports correct errors in the same cycle, including on the same address, the counter rises by two.
- R8: The counter saturates at 7 and never wraps.
- R9: Reading the control register leaves the counter unchanged. A control write loads the counter from bits 13:11, and that value wins over corrections made in the same cycle.
- R10: With the disable bit set, reads return the first copy's word, the counter does not change, and no repair is queued. The planted fault is still detected after protection is turned back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en_a | input | 1 | Read port A checking enable |
| rd_addr_a | input | ADDR_W | Read port A address |
| rd_data_a | output | DATA_W | Read port A data, corrected |
| rd_en_b | input | 1 | Read port B checking enable |
| rd_addr_b | input | ADDR_W | Read port B address |
| rd_data_b | output | DATA_W | Read port B data, corrected |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 32 | Control register write data |
| csr_rdata | output | 32 | Control register read value |

## Verification
The bench builds the block with `NREGS = 8` and keeps the 32-bit word. This makes a full sweep feasible: every nonzero register, every single test bit and both copies, each followed by a corrected read and a repaired re-read. A small register count also lets a handful of injected faults drive the counter to saturation. The same configuration reaches the dual-port and same-address double corrections, the write-wins clear, and the disabled-protection case in a few hundred cycles.

// File: rtl/dupar_pkg.sv
package dupar_pkg;
    localparam int CSR_W  = 32;
    localparam int TEST_W = 8;
    localparam int CNT_W  = 3;
    localparam logic [1:0] SCHEME_ID = 2'b10;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [TEST_W-1:0] tbits;
        logic              sel;
        logic              ten;
        logic              dis;
    } ctrl_t;
endpackage

// File: rtl/dupar_parity.sv
module dupar_parity #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = DATA_W / 4
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    for (genvar k = 0; k < CHK_W; k++) begin : g_nib
        assign chk[k] = ^data[4*k +: 4];
    end
endmodule

// File: rtl/dupar_bank.sv
module dupar_bank #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 32,
    parameter int ADDR_W = $clog2(NREGS),
    parameter int CHK_W  = DATA_W / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CHK_W-1:0]  wchk,
    input  logic [ADDR_W-1:0] raddr0,
    input  logic [ADDR_W-1:0] raddr1,
    output logic [DATA_W-1:0] rdata0,
    output logic [DATA_W-1:0] rdata1,
    output logic [CHK_W-1:0]  rchk0,
    output logic [CHK_W-1:0]  rchk1
);
    localparam int ENT_W = DATA_W + CHK_W;

    logic [ENT_W-1:0] mem_q [NREGS];
    logic [ENT_W-1:0] mem_d [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[waddr] = {wchk, wdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign {rchk0, rdata0} = mem_q[raddr0];
    assign {rchk1, rdata1} = mem_q[raddr1];
endmodule

// File: rtl/dupar_ctrl.sv
module dupar_ctrl
    import dupar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic [1:0]       inc,
    output logic [CSR_W-1:0] csr_rdata,
    output ctrl_t            ctrl
);
    ctrl_t st_q, st_d;
    logic [CNT_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + {{(CNT_W-1){1'b0}}, inc};
        st_d.cnt = (sum > {1'b0, CNT_MAX}) ? CNT_MAX : sum[CNT_W-1:0];
        if (csr_we) begin
            st_d.cnt   = csr_wdata[13:11];
            st_d.tbits = csr_wdata[10:3];
            st_d.sel   = csr_wdata[2];
            st_d.ten   = csr_wdata[1];
            st_d.dis   = csr_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl      = st_q;
    assign csr_rdata = {16'b0, SCHEME_ID, st_q.cnt, st_q.tbits, st_q.sel, st_q.ten, st_q.dis};

    AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> st_q.cnt >= $past(st_q.cnt)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> ({1'b0, st_q.cnt} - {1'b0, $past(st_q.cnt)}) <= 4'd2); // R7
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !csr_we) |=> st_q.cnt == CNT_MAX); // R8
    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dis && !csr_we) |=> $stable(st_q.cnt)); // R10
endmodule

// File: rtl/dupar_regfile.sv
module dupar_regfile
    import dupar_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREGS  = 32,
    parameter int ADDR_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_a,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic              rd_en_b,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              csr_we,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata
);
    localparam int CHK_W  = DATA_W / 4;
    localparam int NPORTS = 2;
    localparam int NCOPY  = 2;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [NPORTS-1:0] slot;
    } state_t;

    state_t st_q, st_d;
    ctrl_t  ctrl;

    logic [ADDR_W-1:0] raddr [NPORTS];
    logic              ren   [NPORTS];
    logic [DATA_W-1:0] rout  [NPORTS];
    logic [DATA_W-1:0] bdata [NCOPY][NPORTS];
    logic [CHK_W-1:0]  bchk  [NCOPY][NPORTS];
    logic [CHK_W-1:0]  calc  [NCOPY][NPORTS];
    logic [NPORTS-1:0] corr;
    logic [1:0]        inc;

    logic              wr_go, rep_go, rep_idx, bank_we;
    logic [ADDR_W-1:0] bank_addr;
    logic [DATA_W-1:0] bank_data;
    logic [CHK_W-1:0]  wpar;
    logic [CHK_W-1:0]  wchk [NCOPY];

    assign raddr[0] = rd_addr_a;
    assign raddr[1] = rd_addr_b;
    assign ren[0]   = rd_en_a;
    assign ren[1]   = rd_en_b;
    assign rd_data_a = rout[0];
    assign rd_data_b = rout[1];

    // write path: ordinary writes first, repairs in free cycles
    assign wr_go     = wr_en && (wr_addr != '0);
    assign rep_go    = !wr_en && (st_q.slot[0].vld || st_q.slot[1].vld);
    assign rep_idx   = !st_q.slot[0].vld;
    assign bank_we   = wr_go || rep_go;
    assign bank_addr = wr_go ? wr_addr : st_q.slot[rep_idx].addr;
    assign bank_data = wr_go ? wr_data : st_q.slot[rep_idx].data;

    dupar_parity #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_wpar (
        .data (bank_data),
        .chk  (wpar)
    );

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        assign wchk[c] = (wr_go && ctrl.ten && (ctrl.sel == c[0]))
                       ? (wpar ^ CHK_W'(ctrl.tbits)) : wpar;

        dupar_bank #(.DATA_W(DATA_W), .NREGS(NREGS), .ADDR_W(ADDR_W), .CHK_W(CHK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (bank_we),
            .waddr  (bank_addr),
            .wdata  (bank_data),
            .wchk   (wchk[c]),
            .raddr0 (raddr[0]),
            .raddr1 (raddr[1]),
            .rdata0 (bdata[c][0]),
            .rdata1 (bdata[c][1]),
            .rchk0  (bchk[c][0]),
            .rchk1  (bchk[c][1])
        );

        for (genvar p = 0; p < NPORTS; p++) begin : g_chk
            dupar_parity #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_rpar (
                .data (bdata[c][p]),
                .chk  (calc[c][p])
            );
        end
    end

    // read path: pick the healthy copy and flag corrections
    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            logic bad0, bad1, nz;
            bad0 = (calc[0][p] != bchk[0][p]);
            bad1 = (calc[1][p] != bchk[1][p]);
            nz   = (raddr[p] != '0);
            corr[p] = ren[p] && nz && !ctrl.dis && (bad0 ^ bad1);
            if (!nz)                              rout[p] = '0;
            else if (!ctrl.dis && bad0 && !bad1)  rout[p] = bdata[1][p];
            else                                  rout[p] = bdata[0][p];
        end
        inc = {1'b0, corr[0]} + {1'b0, corr[1]};
    end

    // repair queue next state
    always_comb begin
        st_d = st_q;
        if (rep_go) st_d.slot[rep_idx].vld = 1'b0;
        for (int p = 0; p < NPORTS; p++) begin
            if (wr_go && st_q.slot[p].addr == wr_addr) st_d.slot[p].vld = 1'b0;
        end
        for (int p = 0; p < NPORTS; p++) begin
            if (corr[p] && !(wr_go && wr_addr == raddr[p]) && !st_d.slot[p].vld) begin
                st_d.slot[p].vld  = 1'b1;
                st_d.slot[p].addr = raddr[p];
                st_d.slot[p].data = rout[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dupar_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .inc       (inc),
        .csr_rdata (csr_rdata),
        .ctrl      (ctrl)
    );

    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0)); // R2
    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0)); // R2
    AST_DIS_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.dis |-> (inc == 2'd0)); // R10
    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[15:14] == SCHEME_ID); // R3
endmodule

// File: tb/dupar_regfile_tb.sv
`timescale 1ns/1ps
module dupar_regfile_tb_top;
    localparam int DW = 32;
    localparam int NR = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_a = 1'b0, rd_en_b = 1'b0;
    logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0;
    logic [DW-1:0] rd_data_a, rd_data_b;
    logic          csr_we = 1'b0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    dupar_regfile #(.DATA_W(DW), .NREGS(NR), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] csrv(input int cnt, input int tb, input int sel,
                                         input int te, input int dis);
        return (32'(cnt & 7) << 11) | (32'(tb & 255) << 3) | (32'(sel & 1) << 2)
             | (32'(te & 1) << 1) | 32'(dis & 1);
    endfunction

    function automatic logic [31:0] cnt_now();
        return {29'b0, csr_rdata[13:11]};
    endfunction

    task automatic csr_wr(input logic [31:0] v);
        @(negedge clk); csr_we = 1'b1; csr_wdata = v;
        @(negedge clk); csr_we = 1'b0;
    endtask

    task automatic reg_wr(input int a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd2(input bit ea, input int aa, input bit eb, input int ab,
                       output logic [31:0] da, output logic [31:0] db);
        @(negedge clk);
        rd_en_a = ea; rd_addr_a = AW'(aa); rd_en_b = eb; rd_addr_b = AW'(ab);
        #1; da = rd_data_a; db = rd_data_b;
        @(negedge clk); rd_en_a = 1'b0; rd_en_b = 1'b0;
        #1;
    endtask

    task automatic inject(input int a, input logic [31:0] d, input int copy, input int tb);
        csr_wr(csrv(0, tb, copy, 1, 0));
        reg_wr(a, d);
        csr_wr(csrv(0, 0, 0, 0, 0));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] da, db, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R3 reset csr", csr_rdata, 32'h0000_8000);
        rd2(1, 1, 1, 0, da, db);
        chk("R1 reset word", da, 32'h0);
        chk("R2 zero read", db, 32'h0);

        // R3 field layout and read-only ID
        csr_wr(32'hFFFF_FFFF); #1;
        chk("R3 all ones", csr_rdata, 32'h0000_BFFF);
        csr_wr(32'h0000_0000); #1;
        chk("R3 cleared", csr_rdata, 32'h0000_8000);

        // R1 plain write/read on every register, both ports
        for (int r = 1; r < NR; r++) reg_wr(r, 32'h1357_0000 + 32'(r * 32'h0101));
        for (int r = 1; r < NR; r++) begin
            rd2(1, r, 1, NR - r, da, db);
            chk("R1 port a", da, 32'h1357_0000 + 32'(r * 32'h0101));
            chk("R1 port b", db, 32'h1357_0000 + 32'((NR - r) * 32'h0101));
        end
        chk("R1 no count on clean reads", cnt_now(), 0);

        // R2 writes to address 0 discarded
        reg_wr(0, 32'hDEAD_BEEF);
        rd2(1, 0, 1, 0, da, db);
        chk("R2 zero after write a", da, 0);
        chk("R2 zero after write b", db, 0);
        chk("R2 no count", cnt_now(), 0);

        // R4/R5/R6 sweep: every register, test bit, copy
        for (int r = 1; r < NR; r++) begin
            for (int b = 0; b < 8; b++) begin
                for (int c = 0; c < 2; c++) begin
                    d = 32'h5A3C_0000 ^ 32'(r << 12) ^ 32'(b << 4) ^ 32'(c * 32'h8001);
                    inject(r, d, c, 1 << b);
                    if (((r + b + c) & 1) == 0) begin
                        rd2(1, r, 0, 0, da, db);
                        chk("R5 corrected data", da, d);
                    end else begin
                        rd2(0, 0, 1, r, da, db);
                        chk("R5 corrected data", db, d);
                    end
                    chk("R5 count one", cnt_now(), 1);
                    @(negedge clk);
                    rd2(1, r, 1, r, da, db);
                    chk("R6 repaired no count", cnt_now(), 1);
                end
            end
        end

        // R4 test bits with test enable clear have no effect
        csr_wr(csrv(0, 8'hFF, 0, 0, 0));
        reg_wr(3, 32'hCAFE_0003);
        csr_wr(csrv(0, 0, 0, 0, 0));
        rd2(1, 3, 1, 3, da, db);
        chk("R4 te clear data", da, 32'hCAFE_0003);
        chk("R4 te clear no count", cnt_now(), 0);

        // R7 both ports, different addresses and same address
        inject(1, 32'h1111_1111, 0, 8'h10);
        inject(2, 32'h2222_2222, 1, 8'h02);
        rd2(1, 1, 1, 2, da, db);
        chk("R7 data a", da, 32'h1111_1111);
        chk("R7 data b", db, 32'h2222_2222);
        chk("R7 plus two", cnt_now(), 2);
        inject(4, 32'h4444_0004, 1, 8'h80);
        rd2(1, 4, 1, 4, da, db);
        chk("R7 same addr data", db, 32'h4444_0004);
        chk("R7 same addr plus two", cnt_now(), 2);

        // R8 saturation
        for (int r = 1; r < NR; r++) inject(r, 32'h7700_0000 | 32'(r), r & 1, 8'h01);
        csr_wr(csrv(0, 0, 0, 0, 0));
        rd2(1, 1, 1, 2, da, db);
        rd2(1, 3, 1, 4, da, db);
        rd2(1, 5, 1, 6, da, db);
        chk("R8 six", cnt_now(), 6);
        rd2(1, 7, 0, 0, da, db);
        chk("R8 seven", cnt_now(), 7);
        inject(1, 32'h7700_0001, 0, 8'h01);
        csr_wr(csrv(7, 0, 0, 0, 0));
        rd2(1, 1, 0, 0, da, db);
        chk("R8 saturated", cnt_now(), 7);

        // R9 reads do not clear; writes load; write wins
        @(negedge clk); #1;
        chk("R9 still seven", cnt_now(), 7);
        csr_wr(csrv(5, 0, 0, 0, 0)); #1;
        chk("R9 load five", cnt_now(), 5);
        inject(2, 32'h0000_2002, 0, 8'h04);
        @(negedge clk);
        rd_en_a = 1'b1; rd_addr_a = 3'd2; csr_we = 1'b1; csr_wdata = csrv(0, 0, 0, 0, 0);
        @(negedge clk);
        rd_en_a = 1'b0; csr_we = 1'b0; #1;
        chk("R9 write wins", cnt_now(), 0);

        // R10 disable: no count, no repair
        inject(5, 32'h5555_AAAA, 1, 8'h20);
        csr_wr(csrv(0, 0, 0, 0, 1));
        rd2(1, 5, 1, 5, da, db);
        chk("R10 data", da, 32'h5555_AAAA);
        chk("R10 no count", cnt_now(), 0);
        @(negedge clk);
        csr_wr(csrv(0, 0, 0, 0, 0));
        rd2(1, 5, 0, 0, da, db);
        chk("R10 fault kept", cnt_now(), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule